// File: doc/BRIEF.md
# Aligned Pulse-Per-Second Generator

This block drives a periodic square wave on an output pin. Its edges are placed against a fixed-point system time rather than counted out by a free-running divider. Software loads a 64-bit target time and a 64-bit half-period, both in the same units as the time counter. The half-period is normally one second in those units: 1,000,000,000 shifted left by the active fractional shift.

While the block is armed, the output level flips as soon as the system time is equal to or later than the target. In that same cycle the target moves forward by the half-period, so every later edge stays phase-locked to the time counter. Because the first target is placed on an exact second boundary, each edge falls on a second.

Every edge can set a sticky interrupt flag, which software clears by writing a one to it. The pin is driven only when it is configured as an output and switched to its timing function. Writing zero to the control word stops the wave, pulls the level low, and masks and clears the interrupt.

Top module: `cko_pps_gen`

## Requirements
- R1: After reset, pin_o, pin_oe and irq_o are 0 and target_o is all zeros.
- R2: A write takes effect on the clock edge where wr_en is high. The word addresses are: 0 = target bits 31:0, 1 = target bits 63:32, 2 = half-period bits 31:0, 3 = half-period bits 63:32, 4 = control, 5 = pin setup, 6 = interrupt clear. A target word write is visible on target_o after that edge.
- R3: The control word has bit0 = run, bit1 = lock to time, and bit2 = interrupt enable. At a clock edge where run and lock are both 1, no target word is written, and systime >= target (unsigned, 64 bits), the level flips and target_o becomes target + half-period. Both changes are visible after that edge.
- R4: The compare is greater-or-equal. When systime steps past the target by less than one half-period, exactly one flip and one advance result.
- R5: While run or lock is 0, no flip occurs and target_o holds, however far systime advances.
- R6: When run is 0 at a clock edge, the level is 0 after that edge. Writing zero to the control word therefore forces pin_o low one cycle after the write.
- R7: In the pin setup word, bit0 is drive-out and bit1 is timing-function select. pin_oe equals drive-out. pin_o shows the level only while both bits are 1, and is 0 otherwise.
- R8: An edge with interrupt enable set raises a sticky irq_o. Writing 1 to bit0 of address 6 clears it. If an edge and a clear occur in the same cycle, the edge wins.
- R9: While interrupt enable is 0, the flag is cleared and irq_o stays 0, even though edges still occur.
- R10: The compare and the advance span all 64 bits. A target above 2^32 is not reached by a time that differs only in its low word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| systime | input | 64 | Fixed-point system time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| pin_o | output | 1 | Clock-out pin value |
| pin_oe | output | 1 | Pin output enable |
| irq_o | output | 1 | Sticky edge interrupt request |
| target_o | output | 64 | Time of the next scheduled edge |

## Verification
A wrong target register shows up directly on target_o after the next edge, and it shows up again as an edge that lands on the wrong system time sample. A scoreboard detects both of these at the cycle the pin flips. A level register that drifts out of step inverts pin_o until the next disable. A missed or doubled advance shifts the phase of every later edge by a whole half-period. Faults in the interrupt flag are visible on irq_o in the cycle after the edge or the clear write.

// File: rtl/cko_pkg.sv
package cko_pkg;

    typedef enum logic [2:0] {
        A_TGT_LO = 3'd0,
        A_TGT_HI = 3'd1,
        A_PER_LO = 3'd2,
        A_PER_HI = 3'd3,
        A_CTRL   = 3'd4,
        A_PIN    = 3'd5,
        A_IRQ    = 3'd6
    } cko_addr_e;

    // bit0 run, bit1 lock to time, bit2 interrupt enable
    typedef struct packed {
        logic irq_en;
        logic lock;
        logic run;
    } cko_ctrl_t;

    // bit0 drive-out, bit1 timing-function select
    typedef struct packed {
        logic native;
        logic drive;
    } cko_pin_t;

    function automatic logic cko_armed(input cko_ctrl_t c);
        return c.run & c.lock;
    endfunction

endpackage

// File: rtl/cko_regs.sv
module cko_regs
    import cko_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int TIME_W = 2 * DATA_W,
    localparam int WORDS  = TIME_W / DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TIME_W-1:0] period,
    output cko_ctrl_t         ctrl,
    output cko_pin_t          pincfg,
    output logic [WORDS-1:0]  tgt_we,
    output logic              irq_clr
);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam logic [2:0] TGT_A = 3'(A_TGT_LO) + 3'(w);
        localparam logic [2:0] PER_A = 3'(A_PER_LO) + 3'(w);

        assign tgt_we[w] = wr_en && (wr_addr == TGT_A);

        always_ff @(posedge clk) begin
            if (rst) begin
                period[w*DATA_W +: DATA_W] <= '0;
            end else if (wr_en && wr_addr == PER_A) begin
                period[w*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            pincfg <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) ctrl   <= cko_ctrl_t'(wr_data[2:0]);
            if (wr_addr == A_PIN)  pincfg <= cko_pin_t'(wr_data[1:0]);
        end
    end

    assign irq_clr = wr_en && (wr_addr == A_IRQ) && wr_data[0];

endmodule

// File: rtl/cko_sched.sv
module cko_sched
    import cko_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int TIME_W = 2 * DATA_W,
    localparam int WORDS  = TIME_W / DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] systime,
    input  logic [TIME_W-1:0] period,
    input  cko_ctrl_t         ctrl,
    input  logic [WORDS-1:0]  tgt_we,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TIME_W-1:0] target,
    output logic              level,
    output logic              fire
);

    logic [TIME_W-1:0] next_tgt;

    assign next_tgt = target + period;
    assign fire     = cko_armed(ctrl) && !(|tgt_we) && (systime >= target);

    for (genvar w = 0; w < WORDS; w++) begin : g_tgt
        always_ff @(posedge clk) begin
            if (rst) begin
                target[w*DATA_W +: DATA_W] <= '0;
            end else if (tgt_we[w]) begin
                target[w*DATA_W +: DATA_W] <= wr_data;
            end else if (fire) begin
                target[w*DATA_W +: DATA_W] <= next_tgt[w*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !ctrl.run) begin
            level <= 1'b0;
        end else if (fire) begin
            level <= ~level;
        end
    end

endmodule

// File: rtl/cko_irq.sv
module cko_irq (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic irq_en,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst || !irq_en) begin
            flag <= 1'b0;
        end else if (fire) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/cko_pps_gen.sv
module cko_pps_gen
    import cko_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2*DATA_W-1:0]   systime,
    input  logic                  wr_en,
    input  logic [2:0]            wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  pin_o,
    output logic                  pin_oe,
    output logic                  irq_o,
    output logic [2*DATA_W-1:0]   target_o
);

    localparam int TIME_W = 2 * DATA_W;
    localparam int WORDS  = TIME_W / DATA_W;

    logic [TIME_W-1:0] period_q;
    cko_ctrl_t         ctrl_q;
    cko_pin_t          pin_q;
    logic [WORDS-1:0]  tgt_we;
    logic              irq_clr;
    logic              level_q;
    logic              fire;
    logic              irq_flag;

    cko_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .period  (period_q),
        .ctrl    (ctrl_q),
        .pincfg  (pin_q),
        .tgt_we  (tgt_we),
        .irq_clr (irq_clr)
    );

    cko_sched #(.DATA_W(DATA_W)) u_sched (
        .clk     (clk),
        .rst     (rst),
        .systime (systime),
        .period  (period_q),
        .ctrl    (ctrl_q),
        .tgt_we  (tgt_we),
        .wr_data (wr_data),
        .target  (target_o),
        .level   (level_q),
        .fire    (fire)
    );

    cko_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .irq_en (ctrl_q.irq_en),
        .clr    (irq_clr),
        .flag   (irq_flag)
    );

    assign pin_oe = pin_q.drive;
    assign pin_o  = pin_q.drive & pin_q.native & level_q;
    assign irq_o  = irq_flag;

endmodule

// File: rtl/cko_checker.sv
module cko_checker
    import cko_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [TIME_W-1:0] systime,
    input logic [TIME_W-1:0] target_o,
    input logic [TIME_W-1:0] period,
    input cko_ctrl_t         ctrl,
    input logic              tgt_we_any,
    input logic              level,
    input logic              pin_o,
    input logic              pin_oe,
    input logic              irq_o
);

    logic hit;
    assign hit = ctrl.run && ctrl.lock && !tgt_we_any && (systime >= target_o);

    assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
        hit |=> target_o == $past(target_o + period));

    assert_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        hit |=> level != $past(level));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!hit && !tgt_we_any) |=> $stable(target_o));

    assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |=> !level);

    assert_pin_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !pin_oe |-> !pin_o);

    assert_irq_set_R8: assert property (@(posedge clk) disable iff (rst)
        (hit && ctrl.irq_en) |=> irq_o);

    assert_irq_mask_R9: assert property (@(posedge clk) disable iff (rst)
        !ctrl.irq_en |=> !irq_o);

endmodule

bind cko_pps_gen cko_checker #(.TIME_W(TIME_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .systime    (systime),
    .target_o   (target_o),
    .period     (period_q),
    .ctrl       (ctrl_q),
    .tgt_we_any (|tgt_we),
    .level      (level_q),
    .pin_o      (pin_o),
    .pin_oe     (pin_oe),
    .irq_o      (irq_o)
);

// File: tb/test_cko_pps_gen.sv
module test_cko_pps_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] systime = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pin_o, pin_oe, irq_o;
    logic [63:0] target_o;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic [63:0] t;
        logic        lvl;
        logic [63:0] nxt;
    } exp_t;

    exp_t sb[$];
    logic mon_on   = 1'b0;
    logic last_pin = 1'b0;

    cko_pps_gen i_cko_pps_gen (
        .clk      (clk),
        .rst      (rst),
        .systime  (systime),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pin_o    (pin_o),
        .pin_oe   (pin_oe),
        .irq_o    (irq_o),
        .target_o (target_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [63:0] v);
        @(negedge clk);
        systime = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops one expected edge for each flip of the pin
    always begin
        exp_t e;
        @(posedge clk);
        #2;
        if (mon_on && pin_o !== last_pin) begin
            if (sb.size() == 0) begin
                chk(0, "R3 unexpected edge", 64'(pin_o), 64'(last_pin));
            end else begin
                e = sb.pop_front();
                chk(systime == e.t, "R3 edge time", systime, e.t);
                chk(pin_o == e.lvl, "R3 edge level", 64'(pin_o), 64'(e.lvl));
                chk(target_o == e.nxt, "R3 advanced target", target_o, e.nxt);
            end
        end
        last_pin = pin_o;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        chk(pin_o == 0,     "R1 pin_o",    64'(pin_o),  0);
        chk(pin_oe == 0,    "R1 pin_oe",   64'(pin_oe), 0);
        chk(irq_o == 0,     "R1 irq_o",    64'(irq_o),  0);
        chk(target_o == 0,  "R1 target_o", target_o,    0);

        // R2 setup: pin, half-period 100, target 1000
        wr(3'd5, 32'd3);
        wr(3'd2, 32'd100);
        wr(3'd3, 32'd0);
        wr(3'd0, 32'd1000);
        wr(3'd1, 32'd0);
        chk(target_o == 64'd1000, "R2 target write", target_o, 64'd1000);
        chk(pin_oe == 1, "R7 drive-out", 64'(pin_oe), 1);
        wr(3'd4, 32'd7);

        // scoreboard phase: time steps by 7
        for (int k = 0; k < 6; k++) begin
            exp_t e;
            logic [63:0] tk;
            tk    = 64'd1000 + 64'(100 * k);
            e.t   = ((tk + 64'd6) / 64'd7) * 64'd7;
            e.lvl = (k % 2 == 0);
            e.nxt = tk + 64'd100;
            sb.push_back(e);
        end
        last_pin = pin_o;
        mon_on   = 1'b1;
        for (int v = 7; v <= 1554; v += 7) set_time(64'(v));
        wait_cyc(2);
        mon_on = 1'b0;
        chk(sb.size() == 0, "R3 all edges seen", 64'(sb.size()), 0);

        // R8 sticky flag and write-one-to-clear
        chk(irq_o == 1, "R8 irq set", 64'(irq_o), 1);
        wr(3'd6, 32'd1);
        chk(irq_o == 0, "R8 irq cleared", 64'(irq_o), 0);

        // R9 masked interrupt while edges continue
        wr(3'd4, 32'd3);
        set_time(64'd1610);
        wait_cyc(2);
        chk(pin_o == 1,          "R3 edge unmasked", 64'(pin_o), 1);
        chk(target_o == 64'd1700, "R3 target 1700",  target_o, 64'd1700);
        chk(irq_o == 0,          "R9 irq masked",    64'(irq_o), 0);

        // R4 jump past target
        set_time(64'd1750);
        wait_cyc(3);
        chk(pin_o == 0,           "R4 single flip",    64'(pin_o), 0);
        chk(target_o == 64'd1800, "R4 single advance", target_o, 64'd1800);

        // R5 run without lock, then lock without run
        wr(3'd4, 32'd1);
        set_time(64'd2000);
        wait_cyc(3);
        chk(target_o == 64'd1800, "R5 no lock hold", target_o, 64'd1800);
        chk(pin_o == 0,           "R5 no lock level", 64'(pin_o), 0);
        wr(3'd4, 32'd2);
        wait_cyc(3);
        chk(target_o == 64'd1800, "R5 no run hold", target_o, 64'd1800);

        // R6 catch up to level 1, then disable
        wr(3'd4, 32'd3);
        wait_cyc(5);
        chk(pin_o == 1,           "R3 catch-up level", 64'(pin_o), 1);
        chk(target_o == 64'd2100, "R3 catch-up target", target_o, 64'd2100);
        wr(3'd4, 32'd0);
        wait_cyc(1);
        chk(pin_o == 0, "R6 forced low", 64'(pin_o), 0);
        set_time(64'd3000);
        wait_cyc(3);
        chk(target_o == 64'd2100, "R5 stopped hold", target_o, 64'd2100);

        // R7 timing-function select off
        wr(3'd4, 32'd1);
        wr(3'd5, 32'd1);
        set_time(64'd2999);
        wr(3'd0, 32'd3000);
        wr(3'd1, 32'd0);
        wr(3'd4, 32'd3);
        set_time(64'd3000);
        wait_cyc(2);
        chk(pin_o == 0,           "R7 native off", 64'(pin_o), 0);
        chk(pin_oe == 1,          "R7 oe on",      64'(pin_oe), 1);
        chk(target_o == 64'd3100, "R3 hidden edge", target_o, 64'd3100);
        wr(3'd5, 32'd3);
        chk(pin_o == 1, "R7 native on shows level", 64'(pin_o), 1);
        wr(3'd5, 32'd2);
        chk(pin_oe == 0, "R7 oe off", 64'(pin_oe), 0);
        chk(pin_o == 0,  "R7 pin off", 64'(pin_o), 0);
        wr(3'd5, 32'd3);

        // R10 upper word of the compare
        wr(3'd4, 32'd1);
        set_time(64'h0000_0000_FFFF_FFF0);
        wr(3'd1, 32'd1);
        wr(3'd0, 32'd0);
        wr(3'd4, 32'd3);
        wait_cyc(3);
        chk(pin_o == 1, "R10 low word no edge", 64'(pin_o), 1);
        chk(target_o == 64'h1_0000_0000, "R10 target held", target_o, 64'h1_0000_0000);
        set_time(64'h1_0000_0000);
        wait_cyc(2);
        chk(pin_o == 0, "R10 edge at 2^32", 64'(pin_o), 0);
        chk(target_o == 64'h1_0000_0064, "R10 carry advance", target_o, 64'h1_0000_0064);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule